// File: doc/BRIEF.md
# Multi-Queue Descriptor Manager with Interrupt Vector FIFO

This block keeps a set of small circular word queues in one internal word memory. Every queue has a descriptor. The descriptor holds a write offset, a read offset, a fill threshold, a 4-bit label key and the 12-bit date of the word most recently stored. Queue q owns the 16 memory slots that start at base address q*16. Its two 4-bit offsets count from that base and wrap modulo 16. One slot is always left empty, so a queue holds at most 15 words and its occupancy is (write - read) mod 16.

A producer presents a store request: queue number, label key, 32-bit word and timestamp. The block refuses the store if the key does not match the descriptor key or if the queue is full. A host pops words through the read port and receives the word, the queue's date and the occupancy left behind. Three events push a 9-bit vector into a 16-deep interrupt FIFO: a queue reaching its threshold, a key mismatch and an overflow. The interrupt line stays high while that FIFO holds any vector, and the host pops vectors one at a time. A configuration port sets each queue's threshold and key and empties the queue.

Top module: `qdesc_mgr`

## Requirements
- R1: After reset every queue is empty (reads miss), irq_o is 0 and irq_lost_o is 0.
- R2: A store whose key equals the queue's key and which finds fewer than 15 words is accepted. st_done_o pulses in the next cycle with st_err_o and st_ovf_o low. Words read back in the order they were stored.
- R3: A read of an empty queue returns rd_done_o=1 and rd_hit_o=0 one cycle later and changes no state.
- R4: A store whose key differs from the queue's key is refused. It gives st_err_o=1 even when the queue is also full, leaves the queue unchanged and pushes the vector {1'b1, queue[7:0]}.
- R5: A queue holds at most 15 words. A store with a matching key to a full queue is refused with st_ovf_o=1, leaves the contents unchanged and pushes the vector {1'b1, queue[7:0]}.
- R6: An accepted store that raises occupancy from N-1 to N, where N is the queue's nonzero threshold, pushes the vector {1'b0, queue[7:0]}. Later stores do not push again until occupancy falls and rises to N again. N=0 disables the threshold.
- R7: rd_date_o reports the timestamp of the queue's last accepted store. Refused stores do not change it.
- R8: irq_o is 1 exactly while the interrupt FIFO holds a vector. irq_vec_o shows the oldest vector, and a pulse on irq_pop_i removes it. Vectors leave in push order, up to 16 at a time.
- R9: A push into a full interrupt FIFO is dropped and sets irq_lost_o, which stays set until reset.
- R10: Offsets wrap modulo 16, so data stays correct over any number of store/read cycles. rd_level_o gives the occupancy left after a read.
- R11: Queues are independent. Interleaved traffic to different queues never mixes their words.
- R12: A configuration write loads the threshold and key and clears the queue's offsets and date, which empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_q_i | input | QW | Queue to configure |
| cfg_thr_i | input | 4 | Threshold N (0 disables) |
| cfg_key_i | input | 4 | Label key |
| st_valid_i | input | 1 | Store request |
| st_q_i | input | QW | Store target queue |
| st_key_i | input | 4 | Label key of the word |
| st_data_i | input | 32 | Word to store |
| st_date_i | input | 12 | Timestamp of the word |
| st_done_o | output | 1 | Store handled (one cycle later) |
| st_err_o | output | 1 | Store refused for key mismatch |
| st_ovf_o | output | 1 | Store refused, queue full |
| rd_valid_i | input | 1 | Read request |
| rd_q_i | input | QW | Read target queue |
| rd_done_o | output | 1 | Read handled |
| rd_hit_o | output | 1 | A word was returned |
| rd_data_o | output | 32 | Returned word |
| rd_date_o | output | 12 | Queue date |
| rd_level_o | output | 4 | Occupancy after the read |
| irq_pop_i | input | 1 | Remove the oldest vector |
| irq_o | output | 1 | Interrupt FIFO not empty |
| irq_vec_o | output | 9 | Oldest vector: bit 8 error/overflow, bits 7:0 queue |
| irq_lost_o | output | 1 | Sticky: a vector was dropped |

## Verification
The bench fills one queue past capacity. This checks that the 16th store is refused as an overflow and not accepted into a slot that aliases the read offset; such a design would corrupt the queue and report occupancy 0. A wrong key sent to a full queue must report the key error, so a design with the checks in the wrong order would flag overflow. Long store/read sweeps cross the pointer wrap many times, and a threshold of 1 sends repeated edge-triggered interrupts into a full vector FIFO. A level-triggered threshold, an off-by-one capacity or a FIFO that overwrites instead of dropping would show up as wrong vectors, a missing lost flag or wrong read data.

// File: rtl/qdm_pkg.sv
package qdm_pkg;
  localparam int PTR_W  = 4;
  localparam int KEY_W  = 4;
  localparam int DATE_W = 12;
  localparam int WORD_W = 32;
  localparam int VEC_W  = 9;

  typedef struct packed {
    logic [PTR_W-1:0]  wp;
    logic [PTR_W-1:0]  rp;
    logic [PTR_W-1:0]  thr;
    logic [KEY_W-1:0]  key;
    logic [DATE_W-1:0] date;
  } desc_t;
endpackage

// File: rtl/qdm_word_ram.sv
module qdm_word_ram #(
  parameter int AW = 10,
  parameter int W  = 32
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/qdm_irq_fifo.sv
module qdm_irq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] vec_i,
  input  logic         pop_i,
  output logic         nempty_o,
  output logic [W-1:0] head_o,
  output logic         lost_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          lost_q;
  logic          full, empty, do_pop, do_push;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop_i && !empty;
  assign do_push = push_i && (!full || do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      cnt_q  <= cnt_q + CW'(do_push) - CW'(do_pop);
      lost_q <= lost_q | (push_i && !do_push);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= vec_i;
  end

  assign nempty_o = !empty;
  assign head_o   = mem_q[rd_q];
  assign lost_o   = lost_q;

  AST_LOST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_q |=> lost_q); // R9
  AST_PUSH_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> nempty_o); // R8
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_push && !do_pop |=> cnt_q <= CW'(DEPTH)); // R8
endmodule

// File: rtl/qdesc_mgr.sv
module qdesc_mgr
  import qdm_pkg::*;
#(
  parameter int NUM_Q     = 64,
  parameter int IRQ_DEPTH = 16,
  localparam int QW       = $clog2(NUM_Q)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [QW-1:0]     cfg_q_i,
  input  logic [PTR_W-1:0]  cfg_thr_i,
  input  logic [KEY_W-1:0]  cfg_key_i,
  input  logic              st_valid_i,
  input  logic [QW-1:0]     st_q_i,
  input  logic [KEY_W-1:0]  st_key_i,
  input  logic [WORD_W-1:0] st_data_i,
  input  logic [DATE_W-1:0] st_date_i,
  output logic              st_done_o,
  output logic              st_err_o,
  output logic              st_ovf_o,
  input  logic              rd_valid_i,
  input  logic [QW-1:0]     rd_q_i,
  output logic              rd_done_o,
  output logic              rd_hit_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [DATE_W-1:0] rd_date_o,
  output logic [PTR_W-1:0]  rd_level_o,
  input  logic              irq_pop_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic              irq_lost_o
);
  localparam int AW = QW + PTR_W;
  localparam logic [PTR_W-1:0] MAX_OCC = '1;

  desc_t desc_q [NUM_Q];
  desc_t st_d, rd_d;

  logic [PTR_W-1:0] st_occ, rd_occ;
  logic             key_bad, full, st_acc, rd_acc, same_q, thr_hit;
  logic             irq_push;
  logic [VEC_W-1:0] irq_vec;

  assign st_d    = desc_q[st_q_i];
  assign rd_d    = desc_q[rd_q_i];
  assign st_occ  = st_d.wp - st_d.rp;
  assign rd_occ  = rd_d.wp - rd_d.rp;
  assign key_bad = (st_key_i != st_d.key);
  assign full    = (st_occ == MAX_OCC);
  assign st_acc  = st_valid_i && !key_bad && !full;
  assign rd_acc  = rd_valid_i && (rd_occ != '0);
  assign same_q  = (st_q_i == rd_q_i);

  // fires on the N-1 -> N transition only; a same-queue read cancels the rise
  assign thr_hit = st_acc && !(rd_acc && same_q) && (st_d.thr != '0)
                   && ((st_occ + 1'b1) == st_d.thr);

  assign irq_push = st_valid_i && (key_bad || full || thr_hit);
  assign irq_vec  = {st_valid_i && (key_bad || full), 8'(st_q_i)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_Q; i++) desc_q[i] <= '0;
    end else begin
      if (rd_acc) desc_q[rd_q_i].rp <= rd_d.rp + 1'b1;
      if (st_acc) begin
        desc_q[st_q_i].wp   <= st_d.wp + 1'b1;
        desc_q[st_q_i].date <= st_date_i;
      end
      if (cfg_we_i)
        desc_q[cfg_q_i] <= '{wp: '0, rp: '0, thr: cfg_thr_i, key: cfg_key_i, date: '0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_done_o  <= 1'b0;
      st_err_o   <= 1'b0;
      st_ovf_o   <= 1'b0;
      rd_done_o  <= 1'b0;
      rd_hit_o   <= 1'b0;
      rd_date_o  <= '0;
      rd_level_o <= '0;
    end else begin
      st_done_o  <= st_valid_i;
      st_err_o   <= st_valid_i && key_bad;
      st_ovf_o   <= st_valid_i && !key_bad && full;
      rd_done_o  <= rd_valid_i;
      rd_hit_o   <= rd_acc;
      rd_date_o  <= rd_d.date;
      rd_level_o <= rd_occ - PTR_W'(rd_acc);
    end
  end

  qdm_word_ram #(.AW(AW), .W(WORD_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (st_acc),
    .waddr_i ({st_q_i, st_d.wp}),
    .wdata_i (st_data_i),
    .re_i    (rd_acc),
    .raddr_i ({rd_q_i, rd_d.rp}),
    .rdata_o (rd_data_o)
  );

  qdm_irq_fifo #(.DEPTH(IRQ_DEPTH), .W(VEC_W)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (irq_push),
    .vec_i    (irq_vec),
    .pop_i    (irq_pop_i),
    .nempty_o (irq_o),
    .head_o   (irq_vec_o),
    .lost_o   (irq_lost_o)
  );

  AST_ERR_OVF_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_err_o |-> !st_ovf_o); // R4
  AST_OVF_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_ovf_o |-> irq_o); // R5
  AST_HIT_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit_o |-> rd_done_o); // R3
  AST_HIT_LEVEL_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit_o |-> rd_level_o != MAX_OCC); // R5
  AST_THR_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_hit |=> irq_o); // R6
endmodule

// File: tb/qdesc_mgr_bench.sv
module qdesc_mgr_bench;
  localparam int NQ = 4;
  localparam int QW = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 0;
  logic [QW-1:0] cfg_q_i = '0;
  logic [3:0]    cfg_thr_i = '0, cfg_key_i = '0;
  logic          st_valid_i = 0;
  logic [QW-1:0] st_q_i = '0;
  logic [3:0]    st_key_i = '0;
  logic [31:0]   st_data_i = '0;
  logic [11:0]   st_date_i = '0;
  logic          st_done_o, st_err_o, st_ovf_o;
  logic          rd_valid_i = 0;
  logic [QW-1:0] rd_q_i = '0;
  logic          rd_done_o, rd_hit_o;
  logic [31:0]   rd_data_o;
  logic [11:0]   rd_date_o;
  logic [3:0]    rd_level_o;
  logic          irq_pop_i = 0;
  logic          irq_o;
  logic [8:0]    irq_vec_o;
  logic          irq_lost_o;

  always #5 clk = ~clk;

  qdesc_mgr #(.NUM_Q(NQ)) u_qdesc_mgr (.*, .clk_i(clk));

  int n_run = 0, n_fail = 0;

  // reference model
  logic [31:0] mq [NQ][$];
  logic [3:0]  mthr [NQ];
  logic [3:0]  mkey [NQ];
  logic [11:0] mdate [NQ];
  logic [8:0]  mi [$];
  logic        mlost = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mpush(logic [8:0] v);
    if (mi.size() == 16) mlost = 1;
    else mi.push_back(v);
  endtask

  task automatic chk_irq();
    chk("R8", 32'(irq_o), 32'(mi.size() != 0));
    if (mi.size() != 0) chk("R8", 32'(irq_vec_o), 32'(mi[0]));
    chk("R9", 32'(irq_lost_o), 32'(mlost));
  endtask

  task automatic cfg(int q, logic [3:0] thr, logic [3:0] key);
    @(negedge clk);
    cfg_we_i = 1; cfg_q_i = QW'(q); cfg_thr_i = thr; cfg_key_i = key;
    @(negedge clk);
    cfg_we_i = 0;
    mq[q].delete(); mthr[q] = thr; mkey[q] = key; mdate[q] = '0;
  endtask

  task automatic do_store(int q, logic [3:0] key, logic [31:0] d, logic [11:0] dt);
    logic err, ovf, thr;
    @(negedge clk);
    st_valid_i = 1; st_q_i = QW'(q); st_key_i = key; st_data_i = d; st_date_i = dt;
    err = (key != mkey[q]);
    ovf = !err && (mq[q].size() == 15);
    thr = 0;
    if (err || ovf) mpush({1'b1, 8'(q)});
    else begin
      mq[q].push_back(d);
      mdate[q] = dt;
      thr = (mthr[q] != 0) && (mq[q].size() == int'(mthr[q]));
      if (thr) mpush({1'b0, 8'(q)});
    end
    @(negedge clk);
    st_valid_i = 0;
    chk("R2", 32'(st_done_o), 1);
    chk("R4", 32'(st_err_o), 32'(err));
    chk("R5", 32'(st_ovf_o), 32'(ovf));
    if (thr) chk("R6", 32'(irq_o), 1);
    chk_irq();
  endtask

  task automatic do_read(int q, string tag);
    logic [31:0] d;
    logic hit;
    @(negedge clk);
    rd_valid_i = 1; rd_q_i = QW'(q);
    hit = (mq[q].size() != 0);
    d = hit ? mq[q].pop_front() : 32'h0;
    @(negedge clk);
    rd_valid_i = 0;
    chk("R3", 32'(rd_done_o), 1);
    chk(hit ? tag : "R3", 32'(rd_hit_o), 32'(hit));
    if (hit) chk(tag, rd_data_o, d);
    chk("R7", 32'(rd_date_o), 32'(mdate[q]));
    chk("R10", 32'(rd_level_o), 32'(mq[q].size()));
    chk_irq();
  endtask

  task automatic do_pop();
    @(negedge clk);
    irq_pop_i = 1;
    if (mi.size() != 0) void'(mi.pop_front());
    @(negedge clk);
    irq_pop_i = 0;
    chk_irq();
  endtask

  initial begin
    for (int q = 0; q < NQ; q++) begin mthr[q] = 0; mkey[q] = 0; mdate[q] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1", 32'(irq_o), 0);
    chk("R1", 32'(irq_lost_o), 0);
    for (int q = 0; q < NQ; q++) do_read(q, "R1");

    cfg(0, 4, 5); cfg(1, 0, 3); cfg(2, 15, 9); cfg(3, 1, 10);

    // key mismatch, capacity, threshold at 4, overflow, error precedence
    do_store(0, 6, 32'hdead0000, 12'h111);
    for (int i = 0; i < 16; i++) do_store(0, 5, 32'ha0000000 + 32'(i), 12'(100 + 7 * i));
    do_store(0, 6, 32'hbad, 12'h222);
    while (mi.size() != 0) do_pop();
    do_pop();
    for (int i = 0; i < 16; i++) do_read(0, "R2");

    // wrap sweep with interleaved queues; q1 threshold disabled
    for (int k = 0; k < 40; k++) begin
      do_store(1, 3, 32'h10000 * 32'(k) + 32'h5a5, 12'(k * 3));
      do_store(2, 9, 32'hc0de0000 ^ 32'(k * 13), 12'(k * 5 + 1));
      chk("R6", 32'(irq_o), 0);
      do_read(1, "R11");
      do_read(2, "R10");
    end

    // threshold at 15 then overflow, then reconfigure clears queue
    for (int i = 0; i < 16; i++) do_store(2, 9, 32'(i * 1001), 12'(i));
    cfg(2, 15, 9);
    do_read(2, "R12");
    while (mi.size() != 0) do_pop();

    // threshold 1 floods the vector FIFO
    for (int k = 0; k < 20; k++) begin
      do_store(3, 10, 32'(k), 12'(k));
      do_read(3, "R10");
    end
    chk("R9", 32'(irq_lost_o), 1);
    for (int i = 0; i < 17; i++) do_pop();
    chk("R9", 32'(irq_lost_o), 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule